// File: doc/BRIEF.md
# Packed Decimal Add/Subtract Flag Unit

This unit adds or subtracts one pair of packed two-digit decimal bytes. Each byte holds two 4-bit decimal digits. An extend bit takes part in the arithmetic as a carry or borrow. The unit produces a decimal-corrected byte and a new set of condition flags: extend, negative, zero, overflow and carry.

The arithmetic is purely combinational. The byte and the five flags are captured in output registers on a clock edge where `start` is high, and they hold at all other times.

Multi-byte decimal numbers are handled by the caller, one byte per operation, starting from the least significant byte. After each step the caller feeds `ext_out` back to `ext_in` and `zero_out` back to `zero_in`. The zero flag can only be cleared by a nonzero byte and is never set by a zero byte. After a chain it therefore reports whether the whole multi-byte number is zero.

Top module: `bcd_arith_flag_unit`

## Requirements
- R1: With `op_sub`=0, `sum_byte` is the packed decimal value of (dst + src + ext_in) mod 100. `carry_out` is 1 exactly when that sum is 100 or more, for valid packed decimal operands.
- R2: Low digit correction adds 6 to the binary sum. It applies when the low-nibble sum dst[3:0]+src[3:0]+ext_in exceeds 9, and this includes a carry out of the nibble (for example 0x08+0x08 gives 0x16).
- R3: After the low digit correction in addition, an intermediate value above 0x99 gets 0x60 added. `ext_out` and `carry_out` are both 1 when any bit above bit 7 of the corrected value is set.
- R4: With `op_sub`=1 the unit computes dst - src - ext_in. It subtracts 6 on a low-nibble borrow or when the low nibble exceeds 9. It then subtracts 0x60 when the intermediate value is above 0x99. `ext_out` and `carry_out` are 1 on a borrow, so 0x00-0x00 with ext_in=1 gives 0x99 and carry 1.
- R5: `neg_out` equals bit 7 of the corrected result byte.
- R6: In addition, `ovf_out` is bit 7 of (NOT(src XOR dst)) AND (dst XOR result).
- R7: In subtraction, `ovf_out` is bit 7 of (src XOR dst) AND (dst XOR result).
- R8: `zero_out` becomes `zero_in` AND (result byte == 0). A zero byte never sets it, and a nonzero byte always clears it.
- R9: The result and all flags update only at a rising clock edge with `start`=1. Otherwise they hold, whatever the other inputs do.
- R10: A synchronous reset (`rst`=1 at a rising edge) sets the result to 0x00, sets `zero_out` to 1 and clears the extend, negative, overflow and carry flags.
- R11: For valid packed decimal operands, each nibble of the result is 9 or less, in both addition and subtraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture the computed result and flags at this edge |
| op_sub | input | 1 | 0 selects addition, 1 selects subtraction |
| src_byte | input | 8 | Source packed decimal byte |
| dst_byte | input | 8 | Destination packed decimal byte (minuend in subtraction) |
| ext_in | input | 1 | Extend bit used as carry-in or borrow-in |
| zero_in | input | 1 | Current zero flag, kept only for a zero result |
| sum_byte | output | 8 | Registered decimal-corrected result |
| ext_out | output | 1 | Registered extend flag |
| neg_out | output | 1 | Registered negative flag |
| zero_out | output | 1 | Registered sticky zero flag |
| ovf_out | output | 1 | Registered overflow flag |
| carry_out | output | 1 | Registered carry/borrow flag |

## Verification
The unit has no top-level parameters; the bench builds it in its only configuration, a single byte of two decimal digits with a 12-bit internal working width. Each operand then has only a hundred valid decimal values. This makes it practical to sweep a lattice of operand pairs in both directions against a plain decimal model that uses integer division and remainder. A hand-worked vector table reaches the edge cases: nibble carry, the 0x99 threshold, borrow wrap, the overflow sign rules and the sticky zero behaviour. A two-byte chain shows that the zero flag stays clear after a nonzero low byte.

// File: rtl/bcd_flag_pkg.sv
package bcd_flag_pkg;

  localparam int DIG_W  = 4;
  localparam int NDIG   = 2;
  localparam int BYTE_W = DIG_W * NDIG;
  localparam int EXT_W  = BYTE_W + DIG_W;

  localparam logic [EXT_W-1:0] LOW_ADJ  = EXT_W'(6);
  localparam logic [EXT_W-1:0] HIGH_ADJ = EXT_W'(8'h60);
  localparam logic [EXT_W-1:0] DEC_TOP  = EXT_W'(8'h99);

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  localparam ccr_t CCR_RESET = '{x: 1'b0, n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};

  function automatic logic [EXT_W-1:0] widen_byte(input logic [BYTE_W-1:0] b);
    return {{(EXT_W-BYTE_W){1'b0}}, b};
  endfunction

  function automatic logic [EXT_W-1:0] widen_bit(input logic b);
    return {{(EXT_W-1){1'b0}}, b};
  endfunction

  // Plain binary sum or difference including the extend bit.
  function automatic logic [EXT_W-1:0] raw_result(input logic sub,
      input logic [BYTE_W-1:0] d, input logic [BYTE_W-1:0] s, input logic x);
    if (sub) return widen_byte(d) - widen_byte(s) - widen_bit(x);
    else     return widen_byte(d) + widen_byte(s) + widen_bit(x);
  endfunction

  // Low digit needs a correction of 6.
  function automatic logic low_digit_fix(input logic sub,
      input logic [BYTE_W-1:0] d, input logic [BYTE_W-1:0] s, input logic x,
      input logic [EXT_W-1:0] raw);
    logic [DIG_W:0] nib_sum;
    logic [DIG_W:0] nib_need;
    nib_sum  = {1'b0, d[DIG_W-1:0]} + {1'b0, s[DIG_W-1:0]} + {{DIG_W{1'b0}}, x};
    nib_need = {1'b0, s[DIG_W-1:0]} + {{DIG_W{1'b0}}, x};
    if (sub) return ({1'b0, d[DIG_W-1:0]} < nib_need) || (raw[DIG_W-1:0] > DIG_W'(9));
    else     return nib_sum > (DIG_W+1)'(9);
  endfunction

  function automatic logic [EXT_W-1:0] step_adjust(input logic sub,
      input logic [EXT_W-1:0] val, input logic [EXT_W-1:0] amount);
    return sub ? (val - amount) : (val + amount);
  endfunction

  function automatic logic is_dec_byte(input logic [BYTE_W-1:0] b);
    return (b[DIG_W-1:0] <= DIG_W'(9)) && (b[BYTE_W-1:DIG_W] <= DIG_W'(9));
  endfunction

endpackage

// File: rtl/bcd_digit_adjust.sv
module bcd_digit_adjust
  import bcd_flag_pkg::*;
(
  input  logic              op_sub,
  input  logic [BYTE_W-1:0] src_b,
  input  logic [BYTE_W-1:0] dst_b,
  input  logic              ext_b,
  output logic [EXT_W-1:0]  wide_out,
  output logic              low_fix,
  output logic              high_fix
);

  logic [EXT_W-1:0] raw_w;
  logic [EXT_W-1:0] stage1_w;

  always_comb begin
    raw_w    = raw_result(op_sub, dst_b, src_b, ext_b);
    low_fix  = low_digit_fix(op_sub, dst_b, src_b, ext_b, raw_w);
    stage1_w = low_fix ? step_adjust(op_sub, raw_w, LOW_ADJ) : raw_w;
    high_fix = stage1_w > DEC_TOP;
    wide_out = high_fix ? step_adjust(op_sub, stage1_w, HIGH_ADJ) : stage1_w;
  end

endmodule

// File: rtl/bcd_flag_gen.sv
module bcd_flag_gen
  import bcd_flag_pkg::*;
(
  input  logic              op_sub,
  input  logic [BYTE_W-1:0] src_b,
  input  logic [BYTE_W-1:0] dst_b,
  input  logic              zero_b,
  input  logic [EXT_W-1:0]  wide_in,
  output logic [BYTE_W-1:0] res_b,
  output ccr_t              flags
);

  logic [BYTE_W-1:0] same_sign;
  logic [BYTE_W-1:0] dst_flip;
  logic              spill;

  always_comb begin
    res_b     = wide_in[BYTE_W-1:0];
    spill     = |wide_in[EXT_W-1:BYTE_W];
    dst_flip  = dst_b ^ res_b;
    same_sign = op_sub ? (src_b ^ dst_b) : ~(src_b ^ dst_b);
    flags.x   = spill;
    flags.c   = spill;
    flags.n   = res_b[BYTE_W-1];
    flags.z   = zero_b & (res_b == '0);
    flags.v   = same_sign[BYTE_W-1] & dst_flip[BYTE_W-1];
  end

endmodule

// File: rtl/bcd_arith_flag_unit.sv
module bcd_arith_flag_unit
  import bcd_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       op_sub,
  input  logic [7:0] src_byte,
  input  logic [7:0] dst_byte,
  input  logic       ext_in,
  input  logic       zero_in,
  output logic [7:0] sum_byte,
  output logic       ext_out,
  output logic       neg_out,
  output logic       zero_out,
  output logic       ovf_out,
  output logic       carry_out
);

  logic [EXT_W-1:0]  wide_w;
  logic              low_fix_w;
  logic              high_fix_w;
  logic [BYTE_W-1:0] res_w;
  ccr_t              next_ccr;
  ccr_t              ccr_q;
  logic [BYTE_W-1:0] res_q;

  bcd_digit_adjust u_adjust (
    .op_sub   (op_sub),
    .src_b    (src_byte),
    .dst_b    (dst_byte),
    .ext_b    (ext_in),
    .wide_out (wide_w),
    .low_fix  (low_fix_w),
    .high_fix (high_fix_w)
  );

  bcd_flag_gen u_flags (
    .op_sub  (op_sub),
    .src_b   (src_byte),
    .dst_b   (dst_byte),
    .zero_b  (zero_in),
    .wide_in (wide_w),
    .res_b   (res_w),
    .flags   (next_ccr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      ccr_q <= CCR_RESET;
    end else if (start) begin
      res_q <= res_w;
      ccr_q <= next_ccr;
    end
  end

  assign sum_byte  = res_q;
  assign ext_out   = ccr_q.x;
  assign neg_out   = ccr_q.n;
  assign zero_out  = ccr_q.z;
  assign ovf_out   = ccr_q.v;
  assign carry_out = ccr_q.c;

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(sum_byte) && $stable({ext_out, neg_out, zero_out, ovf_out, carry_out})));

  assert_sticky_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !zero_in) |=> !zero_out);

  assert_zero_means_empty_R8: assert property (@(posedge clk) disable iff (rst)
    zero_out |-> (sum_byte == 8'h00));

  assert_digits_valid_R11: assert property (@(posedge clk) disable iff (rst)
    (start && is_dec_byte(src_byte) && is_dec_byte(dst_byte)) |=> is_dec_byte(sum_byte));

  assert_high_fix_spill_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !op_sub && high_fix_w) |=> (carry_out && ext_out));

endmodule

// File: tb/bcd_arith_flag_unit_test.sv
`timescale 1ns/1ps
module bcd_arith_flag_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       op_sub = 1'b0;
  logic [7:0] src_byte = 8'h00;
  logic [7:0] dst_byte = 8'h00;
  logic       ext_in = 1'b0;
  logic       zero_in = 1'b1;
  logic [7:0] sum_byte;
  logic       ext_out, neg_out, zero_out, ovf_out, carry_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bcd_arith_flag_unit uut (
    .clk(clk), .rst(rst), .start(start), .op_sub(op_sub),
    .src_byte(src_byte), .dst_byte(dst_byte), .ext_in(ext_in), .zero_in(zero_in),
    .sum_byte(sum_byte), .ext_out(ext_out), .neg_out(neg_out), .zero_out(zero_out),
    .ovf_out(ovf_out), .carry_out(carry_out)
  );

  // {sub, x, z, src, dst, result, X N Z V C}
  localparam logic [31:0] VEC [0:14] = '{
    {1'b0, 1'b0, 1'b1, 8'h12, 8'h34, 8'h46, 5'b00000},
    {1'b0, 1'b1, 1'b1, 8'h05, 8'h05, 8'h11, 5'b00000},
    {1'b0, 1'b0, 1'b1, 8'h99, 8'h01, 8'h00, 5'b10101},
    {1'b0, 1'b1, 1'b1, 8'h99, 8'h99, 8'h99, 5'b11001},
    {1'b0, 1'b0, 1'b1, 8'h50, 8'h30, 8'h80, 5'b01010},
    {1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 5'b00000},
    {1'b0, 1'b0, 1'b1, 8'h08, 8'h08, 8'h16, 5'b00000},
    {1'b1, 1'b0, 1'b1, 8'h12, 8'h45, 8'h33, 5'b00000},
    {1'b1, 1'b0, 1'b1, 8'h45, 8'h12, 8'h67, 5'b10001},
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 8'h99, 5'b11001},
    {1'b1, 1'b0, 1'b1, 8'h01, 8'h10, 8'h09, 5'b00000},
    {1'b1, 1'b1, 1'b1, 8'h29, 8'h50, 8'h20, 5'b00000},
    {1'b1, 1'b0, 1'b1, 8'h20, 8'h90, 8'h70, 5'b00010},
    {1'b1, 1'b0, 1'b1, 8'h45, 8'h45, 8'h00, 5'b00100},
    {1'b1, 1'b0, 1'b0, 8'h45, 8'h45, 8'h00, 5'b00000}
  };

  localparam string VEC_TAG [0:14] = '{
    "R1 R6", "R2", "R3 R8", "R3 R5", "R5 R6", "R8 sticky", "R2 nibble carry",
    "R4", "R4 R7", "R4 borrow wrap", "R4 low borrow", "R4 ext", "R7", "R8 zero", "R8 sticky"
  };

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [12:0] observed();
    return {sum_byte, ext_out, neg_out, zero_out, ovf_out, carry_out};
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual res=%h XNZVC=%b expected res=%h XNZVC=%b",
               req, act[12:5], act[4:0], exp[12:5], exp[4:0]);
    end
  endtask

  task automatic run_op(input logic s, input logic x, input logic z,
                        input logic [7:0] sb, input logic [7:0] db);
    @(negedge clk);
    op_sub = s; ext_in = x; zero_in = z; src_byte = sb; dst_byte = db; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    check("R10 reset", observed(), {8'h00, 5'b00100});
    rst = 1'b0;

    // Vector table
    for (int i = 0; i < 15; i++) begin
      run_op(VEC[i][31], VEC[i][30], VEC[i][29], VEC[i][28:21], VEC[i][20:13]);
      check(VEC_TAG[i], observed(), VEC[i][12:0]);
    end

    // R9: hold while start is low, inputs change
    run_op(1'b0, 1'b0, 1'b1, 8'h27, 8'h36);
    check("R9 before hold", observed(), {8'h63, 5'b00000});
    @(negedge clk);
    op_sub = 1'b1; ext_in = 1'b1; zero_in = 1'b0; src_byte = 8'h99; dst_byte = 8'h00;
    repeat (3) @(negedge clk);
    check("R9 hold", observed(), {8'h63, 5'b00000});

    // R8: two-byte chain, low byte nonzero, high byte zero
    run_op(1'b0, 1'b0, 1'b1, 8'h01, 8'h00);
    check("R8 chain low", observed(), {8'h01, 5'b00000});
    run_op(1'b0, ext_out, zero_out, 8'h00, 8'h00);
    check("R8 chain high zero stays clear", observed(), {8'h00, 5'b00000});

    // R8: chain carrying through, 0x50 0x50 then 0x49 0x50 with carry
    run_op(1'b0, 1'b0, 1'b1, 8'h50, 8'h50);
    check("R8 chain carry low", observed(), {8'h00, 5'b10101});
    run_op(1'b0, ext_out, zero_out, 8'h49, 8'h50);
    check("R3 chain carry high", observed(), {8'h00, 5'b10101});

    // R10: reset after nonzero state
    run_op(1'b0, 1'b1, 1'b1, 8'h99, 8'h99);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset mid-run", observed(), {8'h00, 5'b00100});

    // R1 R4 R11: decimal model sweep
    for (int a = 0; a < 100; a += 7) begin
      for (int b = 0; b < 100; b += 9) begin
        for (int s = 0; s < 2; s++) begin
          int x;
          int t;
          logic cy;
          logic [7:0] er;
          x = (a + b + s) % 2;
          if (s == 0) begin
            t  = a + b + x;
            cy = (t >= 100);
            t  = t % 100;
          end else begin
            t  = a - b - x;
            cy = (t < 0);
            if (t < 0) t = t + 100;
          end
          er = to_bcd(t);
          run_op(s[0], x[0], 1'b1, to_bcd(b), to_bcd(a));
          check(s == 0 ? "R1 R11 sweep add" : "R4 R11 sweep sub",
                {sum_byte, ext_out, carry_out, neg_out, zero_out, 1'b0},
                {er, cy, cy, er[7], (er == 8'h00), 1'b0});
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule